// File: doc/BRIEF.md
# Dual-Select Static RAM Model

A synthesizable behavioural model of a small static memory that holds 256 words of 4 bits each. Writes come in on one bus and reads go out on another. Access is qualified by two chip selects of opposite sense, an active-low output enable and an active-low write enable. True asynchronous behaviour is approximated with a clock. A write is captured on the rising edge when it qualifies. Read data follows the address combinationally.

An access decoder places every input combination in one of four named modes. MODE_DESELECT applies when either select is inactive or reset is asserted. MODE_WRITE applies when the block is selected and write enable is low. MODE_READ applies when the block is selected, write enable is high and output enable is low. MODE_HIDDEN applies when the block is selected, write enable is high and output enable is high. There is no stored state, so there are no transitions to track. The mode moves to the one named by the current inputs in the same cycle. The output is driven only in MODE_READ. In every other mode a valid flag drops and the data output shows the all-ones value that a pull-up would give. Contents are undefined until a location is written.

Top module: `dual_sel_sram`

## Requirements
- R1: On a rising clock edge in MODE_WRITE (sel_n=0, sel_p=1, we_n=0, rst_n=1), din is stored at addr. A later read of that address returns it.
- R2: In MODE_READ (sel_n=0, sel_p=1, we_n=1, oe_n=0), out_valid is 1 and dout equals the word stored at the current addr, in the same cycle.
- R3: When sel_n is 1, out_valid is 0 and dout is 4'hF.
- R4: When sel_p is 0, out_valid is 0 and dout is 4'hF.
- R5: When the block is selected with we_n=1 and oe_n=1 (MODE_HIDDEN), out_valid is 0 and dout is 4'hF.
- R6: A write attempt (we_n=0) while sel_n is 1 leaves the addressed word unchanged.
- R7: A write attempt (we_n=0) while sel_p is 0 leaves the addressed word unchanged.
- R8: During MODE_WRITE the output is disabled: out_valid is 0 and dout is 4'hF.
- R9: Whenever out_valid is 0, dout is 4'hF.
- R10: While rst_n is 0, no write is taken and the output is disabled.
- R11: All 256 addresses hold independent words. A pattern written over the whole range reads back word for word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for writes |
| rst_n | input | 1 | Active-low reset; blocks writes and disables the output |
| addr | input | 8 | Word address |
| din | input | 4 | Write data |
| sel_n | input | 1 | Chip select, active low |
| sel_p | input | 1 | Chip select, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| dout | output | 4 | Read data, 4'hF when disabled |
| out_valid | output | 1 | High only while dout is driven from the array |

## Verification
Mode decoding and the pull-up value are combinational, so dout and out_valid are due in the same cycle the controls change. The bench drives inputs on the falling edge and samples one nanosecond later. A write lands on the next rising edge. Its value is therefore checked only from the following falling edge onward, after the write enable has been released. Blocked-write checks read the word back through the normal read path once reset or the deselect has been lifted.

// File: rtl/dss_pkg.sv
package dss_pkg;
    parameter int unsigned DSS_ADDR_W = 8;
    parameter int unsigned DSS_WORD_W = 4;

    typedef enum logic [1:0] {
        MODE_DESELECT = 2'd0,
        MODE_HIDDEN   = 2'd1,
        MODE_READ     = 2'd2,
        MODE_WRITE    = 2'd3
    } access_mode_e;
endpackage

// File: rtl/dss_access_decode.sv
module dss_access_decode
    import dss_pkg::*;
(
    input  logic         rst_n,
    input  logic         sel_n,
    input  logic         sel_p,
    input  logic         oe_n,
    input  logic         we_n,
    output access_mode_e mode,
    output logic         wr_go,
    output logic         drive_on
);
    logic selected;
    assign selected = rst_n && !sel_n && sel_p;

    // mode selection
    always_comb begin
        if (!selected)
            mode = MODE_DESELECT;
        else if (!we_n)
            mode = MODE_WRITE;
        else if (!oe_n)
            mode = MODE_READ;
        else
            mode = MODE_HIDDEN;
    end

    // per-mode controls
    always_comb begin
        wr_go    = 1'b0;
        drive_on = 1'b0;
        unique case (mode)
            MODE_DESELECT: ;
            MODE_HIDDEN:   ;
            MODE_READ:     drive_on = 1'b1;
            MODE_WRITE:    wr_go    = 1'b1;
            default:       ;
        endcase
    end
endmodule

// File: rtl/dss_word_array.sv
module dss_word_array #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned WORD_W = 4
) (
    input  logic              clk,
    input  logic              wr_go,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wr_word,
    output logic [WORD_W-1:0] rd_word
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_go)
            cells[addr] <= wr_word;
    end

    assign rd_word = cells[addr];
endmodule

// File: rtl/dss_out_stage.sv
module dss_out_stage #(
    parameter int unsigned WORD_W = 4
) (
    input  logic              drive_on,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] dout,
    output logic              out_valid
);
    localparam logic PULL_BIT = 1'b1;

    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        assign dout[b] = drive_on ? rd_word[b] : PULL_BIT;
    end

    assign out_valid = drive_on;
endmodule

// File: rtl/dual_sel_sram.sv
module dual_sel_sram
    import dss_pkg::*;
#(
    parameter int unsigned ADDR_W = DSS_ADDR_W,
    parameter int unsigned WORD_W = DSS_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] din,
    input  logic              sel_n,
    input  logic              sel_p,
    input  logic              oe_n,
    input  logic              we_n,
    output logic [WORD_W-1:0] dout,
    output logic              out_valid
);
    access_mode_e      mode;
    logic              wr_go;
    logic              drive_on;
    logic [WORD_W-1:0] rd_word;

    dss_access_decode u_decode (
        .rst_n    (rst_n),
        .sel_n    (sel_n),
        .sel_p    (sel_p),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .mode     (mode),
        .wr_go    (wr_go),
        .drive_on (drive_on)
    );

    dss_word_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
        .clk     (clk),
        .wr_go   (wr_go),
        .addr    (addr),
        .wr_word (din),
        .rd_word (rd_word)
    );

    dss_out_stage #(.WORD_W(WORD_W)) u_out (
        .drive_on  (drive_on),
        .rd_word   (rd_word),
        .dout      (dout),
        .out_valid (out_valid)
    );
endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned WORD_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [WORD_W-1:0] din,
    input logic              sel_n,
    input logic              sel_p,
    input logic              oe_n,
    input logic              we_n,
    input logic [WORD_W-1:0] dout,
    input logic              out_valid,
    input logic              wr_go
);
    logic rd_cond;
    assign rd_cond = !sel_n && sel_p && !oe_n && we_n;

    p_write_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_go) && rd_cond && addr == $past(addr)) |-> dout == $past(din));
    p_read_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cond |-> out_valid);
    p_seln_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> !out_valid);
    p_selp_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_p |-> !out_valid);
    p_oe_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !out_valid);
    p_seln_nowr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> !wr_go);
    p_selp_nowr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_p |-> !wr_go);
    p_wr_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !out_valid);
    p_pullup_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> dout == '1);
endmodule

bind dual_sel_sram dss_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .din       (din),
    .sel_n     (sel_n),
    .sel_p     (sel_p),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .dout      (dout),
    .out_valid (out_valid),
    .wr_go     (wr_go)
);

// File: tb/dual_sel_sram_tb.sv
module dual_sel_sram_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [3:0] din = 4'h0;
    logic       sel_n = 1'b1;
    logic       sel_p = 1'b0;
    logic       oe_n = 1'b1;
    logic       we_n = 1'b1;
    logic [3:0] dout;
    logic       out_valid;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    dual_sel_sram u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .sel_n(sel_n), .sel_p(sel_p), .oe_n(oe_n), .we_n(we_n),
        .dout(dout), .out_valid(out_valid)
    );

    task automatic check(input string req, input logic [3:0] exp_d, input logic exp_v);
        checks++;
        if (dout !== exp_d || out_valid !== exp_v) begin
            errors++;
            $display("FAIL %s: dout=%h valid=%b expected dout=%h valid=%b",
                     req, dout, out_valid, exp_d, exp_v);
        end
    endtask

    // one write cycle with the given selects
    task automatic do_write(input logic [7:0] a, input logic [3:0] d,
                            input logic sn, input logic sp);
        @(negedge clk);
        addr = a; din = d; sel_n = sn; sel_p = sp; oe_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1; sel_n = 1'b1; sel_p = 1'b0;
    endtask

    task automatic read_expect(input string req, input logic [7:0] a, input logic [3:0] d);
        @(negedge clk);
        addr = a; sel_n = 1'b0; sel_p = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        #1 check(req, d, 1'b1);
    endtask

    task automatic t_reset_state();
        #1 check("R10 reset output", 4'hF, 1'b0);
        @(negedge clk);
        sel_n = 1'b0; sel_p = 1'b1; oe_n = 1'b0;
        #1 check("R10 selected in reset", 4'hF, 1'b0);
        sel_n = 1'b1; sel_p = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_basic_rw();
        do_write(8'h07, 4'h9, 1'b0, 1'b1);
        read_expect("R1 write then read", 8'h07, 4'h9);
        read_expect("R2 read same cycle", 8'h07, 4'h9);
        do_write(8'h07, 4'h6, 1'b0, 1'b1);
        read_expect("R1 overwrite", 8'h07, 4'h6);
    endtask

    task automatic t_disables();
        @(negedge clk);
        addr = 8'h07; sel_n = 1'b1; sel_p = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        #1 check("R3 sel_n high", 4'hF, 1'b0);
        @(negedge clk);
        sel_n = 1'b0; sel_p = 1'b0;
        #1 check("R4 sel_p low", 4'hF, 1'b0);
        @(negedge clk);
        sel_p = 1'b1; oe_n = 1'b1;
        #1 check("R5 oe_n high", 4'hF, 1'b0);
        check("R9 pull-up value", 4'hF, 1'b0);
        @(negedge clk);
        oe_n = 1'b0;
        #1 check("R2 re-enable", 4'h6, 1'b1);
    endtask

    task automatic t_write_disabled_out();
        @(negedge clk);
        addr = 8'h30; din = 4'h0; sel_n = 1'b0; sel_p = 1'b1; oe_n = 1'b0; we_n = 1'b0;
        #1 check("R8 output off while writing", 4'hF, 1'b0);
        @(negedge clk);
        we_n = 1'b1;
        #1 check("R8 then R1 read", 4'h0, 1'b1);
    endtask

    task automatic t_blocked_writes();
        do_write(8'h07, 4'h9, 1'b0, 1'b1);
        do_write(8'h07, 4'h5, 1'b1, 1'b1);
        read_expect("R6 sel_n blocks write", 8'h07, 4'h9);
        do_write(8'h07, 4'h5, 1'b0, 1'b0);
        read_expect("R7 sel_p blocks write", 8'h07, 4'h9);
        do_write(8'h07, 4'h5, 1'b1, 1'b0);
        read_expect("R6 R7 both inactive", 8'h07, 4'h9);
    endtask

    task automatic t_reset_blocks_write();
        do_write(8'h14, 4'h6, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        do_write(8'h14, 4'h1, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        read_expect("R10 reset blocks write", 8'h14, 4'h6);
    endtask

    task automatic t_sweep();
        for (int a = 0; a < 256; a++)
            do_write(8'(a), 4'(a) ^ 4'(a >> 4), 1'b0, 1'b1);
        for (int a = 0; a < 256; a++)
            read_expect("R11 full sweep", 8'(a), 4'(a) ^ 4'(a >> 4));
        for (int a = 0; a < 256; a++)
            do_write(8'(a), ~(4'(a) ^ 4'(a >> 4)), 1'b0, 1'b1);
        for (int a = 0; a < 256; a++)
            read_expect("R11 inverted sweep", 8'(a), ~(4'(a) ^ 4'(a >> 4)));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R11: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_basic_rw();
        t_disables();
        t_write_disabled_out();
        t_blocked_writes();
        t_reset_blocks_write();
        t_sweep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule